// File: doc/BRIEF.md
# State-Retention Register Bank

This block is a bank of data flip-flops that can lose power. Next to the bank sits a shadow copy on the always-on supply. While the domain has power, the functional register works as a normal clocked register with a load enable and a synchronous reset. When the domain loses power, the functional contents become a poison pattern and the valid flag drops. The shadow keeps whatever was last saved into it, and a restore copies the shadow back into the functional register with no recomputation.

The parameter `STYLE` selects one of three control styles:

- **Two inputs:** one input saves and a separate input restores.
- **One input:** a single input saves while high or on its rising edge, and restores on its falling edge.
- **No inputs:** the block saves automatically when power goes away and restores automatically when power returns.

The parameter `SAVE_ON_EDGE` chooses whether a save is level-sensitive or edge-sensitive in the two styles that have inputs.

Top module: `ret_bank`

## Requirements
- R1: On a clock edge with `pwr_on` high, `rst` or `aon_rst` high loads `RESET_VAL` into `q` and sets `q_valid`. Reset has priority over restore, and restore has priority over load.
- R2: On a powered clock edge with no reset and no restore, `ld_en` high loads `d_in` into `q` and sets `q_valid`. With `ld_en` low, `q` holds its value.
- R3: On every clock edge with `pwr_on` low, `q` becomes `POISON` and `q_valid` becomes 0. Load and reset are ignored on such edges.
- R4: In two-input style, a rising edge of `restore_i` on a powered edge copies the shadow into `q`. A save copies the current `q` into the shadow without changing `q`.
- R5: With `SAVE_ON_EDGE`=0, the shadow takes `q` on every powered edge while the save control is active. With `SAVE_ON_EDGE`=1, it takes `q` only on the edge where the control rises, so later loads while the control stays high are not captured.
- R6: In one-input style, `ret_ctl` high (or its rising edge) saves, and a falling edge of `ret_ctl` on a powered edge restores.
- R7: In no-input style, the first edge that sees `pwr_on` low after high saves the old `q`. The first edge that sees `pwr_on` high after low restores it and ignores `ld_en`. Loads resume on the following edge.
- R8: A restore issued when no save has happened since the last `aon_rst` loads `RESET_VAL`.
- R9: In two-input style, when save and restore are both requested on one edge, restore wins and the shadow is left unchanged.
- R10: The shadow keeps its contents across power-down and functional reset. Only `aon_rst` clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous functional reset, active high |
| aon_rst | input | 1 | Synchronous always-on reset, active high; also clears the shadow |
| pwr_on | input | 1 | Domain power good |
| ld_en | input | 1 | Load enable |
| d_in | input | WIDTH | Load data |
| save_i | input | 1 | Save request (two-input style) |
| restore_i | input | 1 | Restore request, rising edge (two-input style) |
| ret_ctl | input | 1 | Combined save/restore control (one-input style) |
| q | output | WIDTH | Functional register value |
| q_valid | output | 1 | High when `q` holds meaningful data |

## Verification
Three copies of the block run side by side:

- two-input style with level-sensitive save;
- one-input style with edge-sensitive save;
- no-input style.

Each copy gets load sequences with distinct data values and a power-down while loads are still being asserted. A save control held high across several loads separates level capture from edge capture. The value that comes back on restore shows which load was retained. A save and a restore on the same edge, followed by a second restore, shows that the shadow was left alone. A restore after an always-on reset, issued before any save, must give the reset value rather than stale data.

// File: rtl/ret_pkg.sv
package ret_pkg;

    typedef enum logic [1:0] {
        STYLE_DUAL   = 2'd0,
        STYLE_SINGLE = 2'd1,
        STYLE_ZERO   = 2'd2
    } ctl_style_e;

    typedef struct packed {
        logic save;
        logic restore;
    } ret_req_t;

    function automatic logic rise(input logic cur, input logic prev);
        return cur & ~prev;
    endfunction

    function automatic logic fall(input logic cur, input logic prev);
        return ~cur & prev;
    endfunction

endpackage

// File: rtl/ret_ctl_decode.sv
module ret_ctl_decode
    import ret_pkg::*;
#(
    parameter ctl_style_e STYLE        = STYLE_DUAL,
    parameter bit         SAVE_ON_EDGE = 1'b0
) (
    input  logic     clk,
    input  logic     aon_rst,
    input  logic     pwr_on,
    input  logic     save_i,
    input  logic     restore_i,
    input  logic     ret_ctl,
    output ret_req_t req
);

    // always-on history samples of the controls and of power
    logic pwr_q, save_q, rest_q, ctl_q;

    always_ff @(posedge clk) begin
        pwr_q  <= pwr_on;
        save_q <= save_i;
        rest_q <= restore_i;
        ctl_q  <= ret_ctl;
    end

    generate
        if (STYLE == STYLE_DUAL) begin : g_dual
            logic sv_raw, rs_raw;
            logic unused_dual;
            assign sv_raw      = SAVE_ON_EDGE ? rise(save_i, save_q) : save_i;
            assign rs_raw      = rise(restore_i, rest_q);
            assign unused_dual = ^{ret_ctl, ctl_q, pwr_q};
            always_comb begin
                req.restore = rs_raw & pwr_on & ~aon_rst;
                req.save    = sv_raw & ~rs_raw & pwr_on & ~aon_rst;
            end
        end else if (STYLE == STYLE_SINGLE) begin : g_single
            logic sv_raw, rs_raw;
            logic unused_single;
            assign sv_raw        = SAVE_ON_EDGE ? rise(ret_ctl, ctl_q) : ret_ctl;
            assign rs_raw        = fall(ret_ctl, ctl_q);
            assign unused_single = ^{save_i, save_q, restore_i, rest_q, pwr_q};
            always_comb begin
                req.restore = rs_raw & pwr_on & ~aon_rst;
                req.save    = sv_raw & ~rs_raw & pwr_on & ~aon_rst;
            end
        end else begin : g_zero
            logic unused_zero;
            assign unused_zero = ^{save_i, save_q, restore_i, rest_q, ret_ctl, ctl_q};
            always_comb begin
                req.restore = rise(pwr_on, pwr_q) & ~aon_rst;
                req.save    = fall(pwr_on, pwr_q) & ~aon_rst;
            end
        end
    endgenerate

endmodule

// File: rtl/ret_shadow_store.sv
module ret_shadow_store
    import ret_pkg::*;
#(
    parameter int              WIDTH     = 16,
    parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
    input  logic             clk,
    input  logic             aon_rst,
    input  ret_req_t         req,
    input  logic [WIDTH-1:0] save_val,
    output logic [WIDTH-1:0] restore_val
);

    logic [WIDTH-1:0] shadow_q;
    logic             has_data;

    always_ff @(posedge clk) begin
        if (aon_rst) begin
            shadow_q <= '0;
            has_data <= 1'b0;
        end else if (req.save) begin
            shadow_q <= save_val;
            has_data <= 1'b1;
        end
    end

    assign restore_val = has_data ? shadow_q : RESET_VAL;

    // R10: without a save the shadow never moves
    assert_shadow_keep_R10: assert property (@(posedge clk) disable iff (aon_rst)
        !req.save |=> ($stable(shadow_q) && $stable(has_data)));

    // R9: a restore edge leaves the shadow as it was
    assert_restore_wins_R9: assert property (@(posedge clk) disable iff (aon_rst)
        req.restore |=> $stable(shadow_q));

endmodule

// File: rtl/ret_func_reg.sv
module ret_func_reg
    import ret_pkg::*;
#(
    parameter int              WIDTH     = 16,
    parameter logic [WIDTH-1:0] RESET_VAL = '0,
    parameter logic [WIDTH-1:0] POISON    = '1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             aon_rst,
    input  logic             pwr_on,
    input  logic             ld_en,
    input  logic [WIDTH-1:0] d_in,
    input  ret_req_t         req,
    input  logic [WIDTH-1:0] restore_val,
    output logic [WIDTH-1:0] q,
    output logic             q_valid
);

    always_ff @(posedge clk) begin
        if (!pwr_on) begin
            q       <= POISON;
            q_valid <= 1'b0;
        end else if (rst || aon_rst) begin
            q       <= RESET_VAL;
            q_valid <= 1'b1;
        end else if (req.restore) begin
            q       <= restore_val;
            q_valid <= 1'b1;
        end else if (ld_en) begin
            q       <= d_in;
            q_valid <= 1'b1;
        end
    end

    assert_poison_R3: assert property (@(posedge clk) disable iff (aon_rst)
        !pwr_on |=> (q == POISON && !q_valid));

    assert_restore_R4: assert property (@(posedge clk) disable iff (aon_rst)
        (pwr_on && req.restore && !rst) |=> (q == $past(restore_val) && q_valid));

    assert_hold_R2: assert property (@(posedge clk) disable iff (aon_rst)
        (pwr_on && !rst && !req.restore && !ld_en) |=> $stable(q));

endmodule

// File: rtl/ret_bank.sv
module ret_bank
    import ret_pkg::*;
#(
    parameter int              WIDTH        = 16,
    parameter ctl_style_e      STYLE        = STYLE_DUAL,
    parameter bit              SAVE_ON_EDGE = 1'b0,
    parameter logic [WIDTH-1:0] RESET_VAL   = '0,
    parameter logic [WIDTH-1:0] POISON      = {(WIDTH/2){2'b10}}
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             aon_rst,
    input  logic             pwr_on,
    input  logic             ld_en,
    input  logic [WIDTH-1:0] d_in,
    input  logic             save_i,
    input  logic             restore_i,
    input  logic             ret_ctl,
    output logic [WIDTH-1:0] q,
    output logic             q_valid
);

    ret_req_t         req;
    logic [WIDTH-1:0] restore_val;

    ret_ctl_decode #(
        .STYLE        (STYLE),
        .SAVE_ON_EDGE (SAVE_ON_EDGE)
    ) u_decode (
        .clk       (clk),
        .aon_rst   (aon_rst),
        .pwr_on    (pwr_on),
        .save_i    (save_i),
        .restore_i (restore_i),
        .ret_ctl   (ret_ctl),
        .req       (req)
    );

    ret_shadow_store #(
        .WIDTH     (WIDTH),
        .RESET_VAL (RESET_VAL)
    ) u_shadow (
        .clk         (clk),
        .aon_rst     (aon_rst),
        .req         (req),
        .save_val    (q),
        .restore_val (restore_val)
    );

    ret_func_reg #(
        .WIDTH     (WIDTH),
        .RESET_VAL (RESET_VAL),
        .POISON    (POISON)
    ) u_func (
        .clk         (clk),
        .rst         (rst),
        .aon_rst     (aon_rst),
        .pwr_on      (pwr_on),
        .ld_en       (ld_en),
        .d_in        (d_in),
        .req         (req),
        .restore_val (restore_val),
        .q           (q),
        .q_valid     (q_valid)
    );

    // R1: a powered reset edge yields the reset value
    assert_reset_R1: assert property (@(posedge clk) disable iff (!pwr_on)
        (rst || aon_rst) |=> (q == RESET_VAL && q_valid));

endmodule

// File: tb/test_ret_bank.sv
module test_ret_bank;
    import ret_pkg::*;

    localparam int         W  = 8;
    localparam logic [7:0] RV = 8'h5A;
    localparam logic [7:0] PZ = 8'hDE;

    logic clk = 1'b0;
    logic rst, aon_rst, pwr_on, ld_en, save_i, restore_i, ret_ctl;
    logic [W-1:0] d_in;
    logic [W-1:0] q0, q1, q2;
    logic         v0, v1, v2;

    always #10 clk = ~clk;

    ret_bank #(.WIDTH(W), .STYLE(STYLE_DUAL), .SAVE_ON_EDGE(1'b0),
               .RESET_VAL(RV), .POISON(PZ)) i_ret_bank (
        .clk(clk), .rst(rst), .aon_rst(aon_rst), .pwr_on(pwr_on), .ld_en(ld_en),
        .d_in(d_in), .save_i(save_i), .restore_i(restore_i), .ret_ctl(ret_ctl),
        .q(q0), .q_valid(v0));

    ret_bank #(.WIDTH(W), .STYLE(STYLE_SINGLE), .SAVE_ON_EDGE(1'b1),
               .RESET_VAL(RV), .POISON(PZ)) i_ret_bank_single (
        .clk(clk), .rst(rst), .aon_rst(aon_rst), .pwr_on(pwr_on), .ld_en(ld_en),
        .d_in(d_in), .save_i(save_i), .restore_i(restore_i), .ret_ctl(ret_ctl),
        .q(q1), .q_valid(v1));

    ret_bank #(.WIDTH(W), .STYLE(STYLE_ZERO), .SAVE_ON_EDGE(1'b0),
               .RESET_VAL(RV), .POISON(PZ)) i_ret_bank_zero (
        .clk(clk), .rst(rst), .aon_rst(aon_rst), .pwr_on(pwr_on), .ld_en(ld_en),
        .d_in(d_in), .save_i(save_i), .restore_i(restore_i), .ret_ctl(ret_ctl),
        .q(q2), .q_valid(v2));

    typedef struct {
        int         unit;
        logic [7:0] q;
        logic       v;
        string      req;
    } exp_t;

    exp_t sbq[$];
    int   checks = 0;
    int   errors = 0;
    bit   done   = 1'b0;

    task automatic expect_one(input int unit, input logic [7:0] eq, input logic ev, input string req);
        exp_t e;
        e.unit = unit; e.q = eq; e.v = ev; e.req = req;
        sbq.push_back(e);
    endtask

    task automatic expect_all(input logic [7:0] eq, input logic ev, input string req);
        for (int u = 0; u < 3; u++) expect_one(u, eq, ev, req);
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    // monitor: compares after each edge, well before the next input change
    always @(posedge clk) begin
        #5;
        while (sbq.size() > 0) begin
            exp_t e;
            logic [7:0] aq;
            logic       av;
            e = sbq.pop_front();
            case (e.unit)
                0:       begin aq = q0; av = v0; end
                1:       begin aq = q1; av = v1; end
                default: begin aq = q2; av = v2; end
            endcase
            checks++;
            if (aq !== e.q || av !== e.v) begin
                errors++;
                $display("FAIL %s unit%0d: q=%h valid=%b expected q=%h valid=%b",
                         e.req, e.unit, aq, av, e.q, e.v);
            end
        end
    end

    initial begin
        rst = 1; aon_rst = 1; pwr_on = 1; ld_en = 0; d_in = '0;
        save_i = 0; restore_i = 0; ret_ctl = 0;
        tick(); tick();
        expect_all(RV, 1'b1, "R1 reset");
        tick();
        rst = 0; aon_rst = 0;
        tick();
        // R2 loads with distinct patterns
        ld_en = 1; d_in = 8'h3C; expect_all(8'h3C, 1'b1, "R2 load"); tick();
        d_in = 8'hA5;             expect_all(8'hA5, 1'b1, "R2 load"); tick();
        ld_en = 0; d_in = 8'hFF;  expect_all(8'hA5, 1'b1, "R2 hold"); tick();
        // save A5: dual level, single rising edge; q unchanged (R4)
        save_i = 1; ret_ctl = 1;  expect_all(8'hA5, 1'b1, "R4 save keeps q"); tick();
        save_i = 0; ld_en = 1; d_in = 8'h11; expect_all(8'h11, 1'b1, "R5 load with ctl high"); tick();
        // power down with loads still requested (R3)
        pwr_on = 0; d_in = 8'h77; expect_all(PZ, 1'b0, "R3 poison"); tick();
        expect_all(PZ, 1'b0, "R3 clock ignored"); tick();
        // power up with restore requests and a load (R4, R5, R6, R7, R10)
        pwr_on = 1; restore_i = 1; ret_ctl = 0;
        expect_one(0, 8'hA5, 1'b1, "R4 R10 dual restore");
        expect_one(1, 8'hA5, 1'b1, "R5 R6 single edge save restore");
        expect_one(2, 8'h11, 1'b1, "R7 zero restore ignores load");
        tick();
        restore_i = 0; expect_all(8'h77, 1'b1, "R7 load resumes"); tick();
        // R9 simultaneous save and restore in dual style
        ld_en = 0; save_i = 1; restore_i = 1;
        expect_one(0, 8'hA5, 1'b1, "R9 restore wins"); tick();
        save_i = 0; restore_i = 0; ld_en = 1; d_in = 8'h22;
        expect_one(0, 8'h22, 1'b1, "R2 load"); tick();
        ld_en = 0; restore_i = 1;
        expect_one(0, 8'hA5, 1'b1, "R9 shadow unchanged"); tick();
        restore_i = 0;
        // R8 / R10: always-on reset clears shadow while unpowered
        pwr_on = 0; ret_ctl = 1; expect_all(PZ, 1'b0, "R3 poison"); tick();
        aon_rst = 1; tick();
        aon_rst = 0; expect_all(PZ, 1'b0, "R3 reset ignored"); tick();
        pwr_on = 1; restore_i = 1; ret_ctl = 0; ld_en = 1; d_in = 8'h44;
        expect_all(RV, 1'b1, "R8 R10 restore without save"); tick();
        restore_i = 0; ld_en = 0; tick();
        // R5 level save in dual style captures each edge
        save_i = 1; ld_en = 1; d_in = 8'h01; tick();
        d_in = 8'h02; tick();
        save_i = 0; d_in = 8'h03; expect_one(0, 8'h03, 1'b1, "R2 load"); tick();
        ld_en = 0; restore_i = 1;
        expect_one(0, 8'h01, 1'b1, "R5 level save each edge"); tick();
        restore_i = 0;
        // R1 / R3 functional reset ignored unpowered, wins over restore when powered
        pwr_on = 0; rst = 1; expect_all(PZ, 1'b0, "R3 reset unpowered"); tick();
        pwr_on = 1; expect_all(RV, 1'b1, "R1 reset over restore"); tick();
        rst = 0; tick(); tick();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(20 * 5000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule